// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block sits beside the SECDED checker on a memory read path and logs the first ECC event it reports. A correctable event arrives as a one-cycle single-bit pulse and an uncorrectable event as a one-cycle multi-bit pulse. Each pulse comes with the failing 32-bit address and the 8-bit syndrome. On the first event the block latches the upper address bits and the syndrome, and sets the status bit for that event type. It then ignores every later event until software has cleared the status.

Software reaches the block through one 32-bit register on a simple read/write port. Three control bits live in that register. One suppresses the write-back of corrected reads. One lets a captured single-bit error raise an NMI request. One lets a captured multi-bit error raise a system-error output.

Both interrupt outputs are levels. Each one stays asserted for as long as its status bit and its enable bit are both set.

Top module: `ecc_fault_capture`

## Requirements
- R1: After reset, `rd_data` reads 0: both status bits, the address field, the syndrome field and all control bits are 0. `scrub_en` is 1, and `nmi_req` and `serr_out` are 0.
- R2: When no status bit is set and `sbe_in` pulses without `mbe_in`, bit 0 reads 1 from the next cycle on. Bits 30:12 then hold `err_addr[31:13]` and bits 11:4 hold `err_syn` from the pulse cycle.
- R3: When no status bit is set and `mbe_in` pulses, bit 1 reads 1 from the next cycle on, and the address and syndrome are captured as in R2.
- R4: When both pulses arrive in the same cycle with no status bit set, only bit 1 is set. At most one status bit is ever set.
- R5: While bit 0 or bit 1 is set, further pulses change neither the status bits nor bits 30:4.
- R6: A write with `wr_data` bit 0 = 1 clears bit 0, and a write with bit 1 = 1 clears bit 1. Writing 0 to these bits leaves them unchanged. Once both bits are clear, the next pulse is captured. A pulse that arrives in the same cycle as a clearing write is dropped.
- R7: A write loads bits 31, 3 and 2 from `wr_data`. Writes leave bits 30:4 unchanged, and `rd_data` always shows the current register value.
- R8: `nmi_req` equals bit 0 AND bit 2 (the NMI enable).
- R9: `serr_out` equals bit 1 AND bit 3 (the system-error enable).
- R10: `scrub_en` equals NOT bit 31, so setting bit 31 suppresses write-back of corrected reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| sbe_in | input | 1 | Single-bit (corrected) error pulse |
| mbe_in | input | 1 | Multi-bit (uncorrectable) error pulse |
| err_addr | input | 32 | Failing address that goes with the pulse |
| err_syn | input | 8 | Syndrome that goes with the pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| nmi_req | output | 1 | NMI request level |
| serr_out | output | 1 | System-error level |
| scrub_en | output | 1 | Enables write-back of corrected reads |

## Verification
The bench first runs directed patterns, each of which separates one pair of possible behaviours:
- A lone single-bit pulse against a lone multi-bit pulse shows that the correct status bit is chosen.
- Pulses that arrive in the same cycle expose the priority.
- A second pulse while an error is pending shows whether the first error is kept or overwritten.
- Writes of 0 and of 1 to the status bits, and writes of all-ones to the read-only fields, show which bits a write can touch.

After that, a long random mix of pulses, clearing writes and control writes is compared every cycle against a behavioural model. This mix catches ordering cases such as a pulse landing in the same cycle as a clear.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  // Bit positions of the single-bit fields. Software decodes these positions.
  localparam int unsigned SBE_BIT       = 0;
  localparam int unsigned MBE_BIT       = 1;
  localparam int unsigned NMI_EN_BIT    = 2;
  localparam int unsigned SERR_EN_BIT   = 3;
  localparam int unsigned SYN_LSB       = 4;
  localparam int unsigned LOW_CTRL_BITS = 4;
endpackage

// File: rtl/ecc_cap_status.sv
module ecc_cap_status #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned KEEP_W = 19,
  parameter int unsigned SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_in,
  input  logic              mbe_in,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              clr_sbe,
  input  logic              clr_mbe,
  output logic              sbe_q,
  output logic              mbe_q,
  output logic [KEEP_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q
);
  logic              pending;
  logic              take;
  logic              sbe_d, mbe_d;
  logic [KEEP_W-1:0] addr_d;
  logic [SYN_W-1:0]  syn_d;

  assign pending = sbe_q | mbe_q;
  // Capture only when nothing is pending.
  assign take    = ~pending & (sbe_in | mbe_in);

  always_comb begin
    sbe_d  = sbe_q & ~clr_sbe;
    mbe_d  = mbe_q & ~clr_mbe;
    addr_d = err_addr[ADDR_W-1 -: KEEP_W];
    syn_d  = err_syn;
    if (take) begin
      // The multi-bit pulse wins a same-cycle tie.
      mbe_d = mbe_in;
      sbe_d = ~mbe_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end else begin
      sbe_q <= sbe_d;
      mbe_q <= mbe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (take) begin
      addr_q <= addr_d;
      syn_q  <= syn_d;
    end
  end
endmodule

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl #(
  parameter int unsigned CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned KEEP_W = 19,
  parameter int unsigned SYN_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sbe_in,
  input  logic                            mbe_in,
  input  logic [ADDR_W-1:0]               err_addr,
  input  logic [SYN_W-1:0]                err_syn,
  input  logic                            wr_en,
  input  logic [KEEP_W+SYN_W+LOW_CTRL_BITS:0] wr_data,
  output logic [KEEP_W+SYN_W+LOW_CTRL_BITS:0] rd_data,
  output logic                            nmi_req,
  output logic                            serr_out,
  output logic                            scrub_en
);
  localparam int unsigned REG_W    = KEEP_W + SYN_W + LOW_CTRL_BITS + 1;
  localparam int unsigned ADDR_LSB = SYN_LSB + SYN_W;
  localparam int unsigned TOP_BIT  = REG_W - 1;

  logic              sbe_q, mbe_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic [2:0]        ctrl_q;   // {scrub_off, serr_en, nmi_en}
  logic              clr_sbe, clr_mbe;

  assign clr_sbe = wr_en & wr_data[SBE_BIT];
  assign clr_mbe = wr_en & wr_data[MBE_BIT];

  ecc_cap_status #(
    .ADDR_W (ADDR_W),
    .KEEP_W (KEEP_W),
    .SYN_W  (SYN_W)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sbe_in   (sbe_in),
    .mbe_in   (mbe_in),
    .err_addr (err_addr),
    .err_syn  (err_syn),
    .clr_sbe  (clr_sbe),
    .clr_mbe  (clr_mbe),
    .sbe_q    (sbe_q),
    .mbe_q    (mbe_q),
    .addr_q   (addr_q),
    .syn_q    (syn_q)
  );

  ecc_cap_ctrl #(
    .CTRL_W (3)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .ctrl_wdata ({wr_data[TOP_BIT], wr_data[SERR_EN_BIT], wr_data[NMI_EN_BIT]}),
    .ctrl_q     (ctrl_q)
  );

  always_comb begin
    rd_data                              = '0;
    rd_data[TOP_BIT]                     = ctrl_q[2];
    rd_data[ADDR_LSB +: KEEP_W]          = addr_q;
    rd_data[SYN_LSB +: SYN_W]            = syn_q;
    rd_data[SERR_EN_BIT]                 = ctrl_q[1];
    rd_data[NMI_EN_BIT]                  = ctrl_q[0];
    rd_data[MBE_BIT]                     = mbe_q;
    rd_data[SBE_BIT]                     = sbe_q;
  end

  assign nmi_req  = sbe_q & ctrl_q[0];
  assign serr_out = mbe_q & ctrl_q[1];
  assign scrub_en = ~ctrl_q[2];
endmodule

// File: rtl/ecc_fault_capture_chk.sv
module ecc_fault_capture_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned KEEP_W = 19,
  parameter int unsigned SYN_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sbe_in,
  input logic                    mbe_in,
  input logic [ADDR_W-1:0]       err_addr,
  input logic [SYN_W-1:0]        err_syn,
  input logic                    wr_en,
  input logic [KEEP_W+SYN_W+4:0] wr_data,
  input logic [KEEP_W+SYN_W+4:0] rd_data,
  input logic                    nmi_req,
  input logic                    serr_out,
  input logic                    scrub_en
);
  localparam int unsigned TOP_BIT  = KEEP_W + SYN_W + 4;
  localparam int unsigned ADDR_LSB = 4 + SYN_W;

  logic idle;
  assign idle = (rd_data[1:0] == 2'b00);

  assert_mbe_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mbe_in) |=> (rd_data[1] && !rd_data[0]));

  assert_sbe_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sbe_in && !mbe_in) |=>
      (rd_data[0] && rd_data[ADDR_LSB +: KEEP_W] == $past(err_addr[ADDR_W-1 -: KEEP_W])
       && rd_data[4 +: SYN_W] == $past(err_syn)));

  assert_onehot_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_data[1:0]));

  assert_first_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> $stable(rd_data[TOP_BIT-1:4]));

  assert_sbe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !(wr_en && wr_data[0])) |=> rd_data[0]);

  assert_mbe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !(wr_en && wr_data[1])) |=> rd_data[1]);

  assert_nmi_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (rd_data[0] && rd_data[2]));

  assert_serr_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_out == (rd_data[1] && rd_data[3]));

  assert_scrub_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_en == !rd_data[TOP_BIT]);
endmodule

bind ecc_fault_capture ecc_fault_capture_chk #(
  .ADDR_W (ADDR_W),
  .KEEP_W (KEEP_W),
  .SYN_W  (SYN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sbe_in   (sbe_in),
  .mbe_in   (mbe_in),
  .err_addr (err_addr),
  .err_syn  (err_syn),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .nmi_req  (nmi_req),
  .serr_out (serr_out),
  .scrub_en (scrub_en)
);

// File: tb/ecc_fault_capture_tb.sv
`timescale 1ns/1ps
module ecc_fault_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe_in = 1'b0, mbe_in = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        nmi_req, serr_out, scrub_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_fault_capture u_dut (
    .clk(clk), .rst_n(rst_n), .sbe_in(sbe_in), .mbe_in(mbe_in),
    .err_addr(err_addr), .err_syn(err_syn), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .nmi_req(nmi_req), .serr_out(serr_out), .scrub_en(scrub_en)
  );

  // Behavioural reference model
  bit        m_sbe, m_mbe, m_nmien, m_serren, m_scruboff;
  bit [18:0] m_addr;
  bit [7:0]  m_syn;

  function automatic logic [31:0] model_reg();
    return {m_scruboff, m_addr, m_syn, m_serren, m_nmien, m_mbe, m_sbe};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sbe = 0; m_mbe = 0; m_nmien = 0; m_serren = 0; m_scruboff = 0;
      m_addr = '0; m_syn = '0;
    end else begin
      if (!(m_sbe || m_mbe) && (sbe_in || mbe_in)) begin
        if (mbe_in) m_mbe = 1; else m_sbe = 1;
        m_addr = err_addr[31:13];
        m_syn  = err_syn;
      end else if (wr_en) begin
        if (wr_data[0]) m_sbe = 0;
        if (wr_data[1]) m_mbe = 0;
      end
      if (wr_en) begin
        m_scruboff = wr_data[31];
        m_serren   = wr_data[3];
        m_nmien    = wr_data[2];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      e = model_reg();
      if (rd_data[1:0] !== e[1:0])   check("R6 status", {30'b0, rd_data[1:0]}, {30'b0, e[1:0]});
      else if (rd_data[30:4] !== e[30:4]) check("R5 fields", rd_data, e);
      else                           check("R7 register", rd_data, e);
      check("R8 nmi",   {31'b0, nmi_req},  {31'b0, m_sbe & m_nmien});
      check("R9 serr",  {31'b0, serr_out}, {31'b0, m_mbe & m_serren});
      check("R10 scrub", {31'b0, scrub_en}, {31'b0, !m_scruboff});
    end
  end

  task automatic drive(bit s, bit m, logic [31:0] a, logic [7:0] y, bit w, logic [31:0] d);
    sbe_in = s; mbe_in = m; err_addr = a; err_syn = y; wr_en = w; wr_data = d;
    @(negedge clk);
    sbe_in = 0; mbe_in = 0; wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", rd_data, 32'h0);
    check("R1 reset scrub", {31'b0, scrub_en}, 32'h1);
    check("R1 reset irq", {30'b0, nmi_req, serr_out}, 32'h0);

    drive(0, 0, 0, 0, 1, 32'h0000_000C);
    check("R7 ctrl write", rd_data, 32'h0000_000C);

    drive(1, 0, 32'hDEAD_B000, 8'h5A, 0, 0);
    check("R2 sbe capture", rd_data, {1'b0, 19'(32'hDEAD_B000 >> 13), 8'h5A, 4'hD});
    check("R8 nmi on", {31'b0, nmi_req}, 32'h1);

    drive(0, 1, 32'h1234_5678, 8'hA5, 0, 0);
    check("R5 later mbe ignored", rd_data, {1'b0, 19'(32'hDEAD_B000 >> 13), 8'h5A, 4'hD});

    drive(0, 0, 0, 0, 1, 32'h0000_000C);
    check("R6 write zero keeps", {30'b0, rd_data[1:0]}, 32'h1);

    drive(0, 0, 0, 0, 1, 32'h0000_000D);
    check("R6 clear sbe", {30'b0, rd_data[1:0]}, 32'h0);

    drive(0, 1, 32'h8000_2000, 8'h33, 0, 0);
    check("R3 mbe capture", rd_data, {1'b0, 19'(32'h8000_2000 >> 13), 8'h33, 4'hE});
    check("R9 serr on", {31'b0, serr_out}, 32'h1);

    drive(0, 0, 0, 0, 1, 32'h0000_000E);
    drive(1, 1, 32'h4444_E000, 8'hC3, 0, 0);
    check("R4 tie goes to mbe", rd_data, {1'b0, 19'(32'h4444_E000 >> 13), 8'hC3, 4'hE});

    drive(0, 0, 0, 0, 1, 32'hFFFF_FFF3);
    check("R10 scrub off", {31'b0, scrub_en}, 32'h0);
    check("R7 ro fields kept", rd_data, {1'b1, 19'(32'h4444_E000 >> 13), 8'hC3, 4'h0});

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      drive(($urandom % 5) == 0, ($urandom % 7) == 0, $urandom, 8'($urandom),
            ($urandom % 4) == 0, d);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule